// File: doc/BRIEF.md
# Processor Counter/Timer Array with User-Counter Mode

This block holds one counter/timer per processor and a shared mode vector that decides, bit by bit, how each of them behaves. In counter mode a timer counts a 500 ns time base in steps of 512 (bit 9). It returns to zero when it meets a programmed limit, sets a reached flag and raises its interrupt. A limit of zero makes it count freely, with no match and no interrupt. In user mode the same timer becomes a 63-bit free-running count that software reads and loads as an upper and a lower 32-bit word. A status register starts and stops it, and it never interrupts.

Software reaches the block through one word-addressed bus. A window select of zero picks the system window, where only the shared mode vector (offset 4) lives. A select of `p+1` picks the 16-byte window of processor timer `p`. Reads return data in the same cycle. A read of offset 0 in counter mode has a side effect: it acknowledges the timer. Changing a mode bit triggers a defined side effect on that timer only.

Top module: `ptmr_cluster`

## Requirements
- R1: After reset every timer is in counter mode with limit 0, count 0, reached flag 0, run bit 1 and interrupt low, and the mode vector reads 0.
- R2: In counter mode the count (offset 1, bits 30:9, reached flag in bit 31) advances by one step of 512 on every cycle with `tick_i` high, whatever the run bit. When the next step would equal a non-zero limit, the count becomes 0, the reached flag is set and the interrupt rises in the same cycle.
- R3: In counter mode, reading offset 0 returns the limit in bits 30:9 and clears the reached flag and the interrupt. Writing offset 0 loads the limit from bits 30:9, restarts the count at 0 and lowers the interrupt. Writing offset 1 has no effect.
- R4: Writing offset 2 changes the limit without touching the count. A step in the same cycle still uses the old limit.
- R5: With limit 0 the counter-mode count runs without ever setting the reached flag or the interrupt.
- R6: Mode bit `i` sits in bit `i` at offset 4 of the system window and selects user mode for timer `i`. Offset 4 of any processor window reads the same vector, but a write there is ignored.
- R7: In user mode, offset 0 reads {reached, count bits 62:32} and a write loads count bits 62:32 from data bits 30:0. Offset 1 reads count bits 31:9 with bits 8:0 zero, and a write loads count bits 31:9. Either write clears the reached flag and suppresses that cycle's step.
- R8: Offset 3 bit 0 stores the run bit and reads it back. In user mode the count advances only while the run bit is 1. In counter mode the stored bit has no effect on counting.
- R9: In user mode, when the next step would reach all ones in bits 62:9, the count wraps to 0 and the reached flag is set. The interrupt stays low throughout user mode.
- R10: Setting a mode bit lowers that timer's interrupt and clears its count and reached flag, and it keeps the run bit. A mode bit written with its current value causes no side effect.
- R11: Clearing a mode bit returns that timer to counter mode with count 0, limit 0 and reached flag 0, and the count advances again on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 500 ns time-base strobe, one step per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (used for read side effects) |
| bus_sel_i | input | $clog2(NUM_PROC+1) | Window select: 0 system, p+1 processor timer p |
| bus_off_i | input | 3 | Word offset inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register, same cycle |
| irq_o | output | NUM_PROC | Per-timer interrupt, level |

## Verification
The bench aims at the limit match and the wrap in both modes. If the compare is off by one step, the interrupt appears a cycle early or late, and the per-cycle interrupt comparison catches it. It also checks the priorities inside a single cycle. A design that let a word load and a step collide, or that applied a fresh limit or run bit one cycle early, would read back a count one step away from the model. Mode changes are driven on one bit while the other bit is rewritten unchanged. A design that compared against the written value rather than the old mode would reset the wrong timer's count or drop an interrupt that should stay. Writing the mode offset through a processor window must leave the vector untouched on the system-window read.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  // count is held in units of the 512 step (bit 9 of the visible value)
  localparam int unsigned PT_STEP_LSB = 9;
  localparam int unsigned PT_CNT_W    = 63 - PT_STEP_LSB;   // user-mode count field
  localparam int unsigned PT_LIM_W    = 31 - PT_STEP_LSB;   // counter-mode field
  localparam int unsigned PT_LO_W     = 32 - PT_STEP_LSB;   // user lower word field
  localparam int unsigned PT_HI_W     = PT_CNT_W - PT_LO_W; // user upper word field

  localparam logic [2:0] PT_OFF_HI   = 3'd0; // limit / upper word
  localparam logic [2:0] PT_OFF_LO   = 3'd1; // count / lower word
  localparam logic [2:0] PT_OFF_LIMK = 3'd2; // limit, count kept
  localparam logic [2:0] PT_OFF_RUN  = 3'd3; // run bit
  localparam logic [2:0] PT_OFF_MODE = 3'd4; // shared mode vector

  typedef struct packed {
    logic [PT_CNT_W-1:0] cnt;
    logic                hit;
  } pt_step_t;

  // one time-base step of either mode
  function automatic pt_step_t pt_step(input logic [PT_CNT_W-1:0] cnt,
                                       input logic user,
                                       input logic [PT_LIM_W-1:0] lim);
    pt_step_t r;
    logic [PT_LIM_W-1:0] nxt_small;
    nxt_small = cnt[PT_LIM_W-1:0] + PT_LIM_W'(1);
    if (user) begin
      r.cnt = cnt + PT_CNT_W'(1);
      r.hit = &r.cnt;
      if (r.hit) r.cnt = '0;
    end else begin
      r.hit = (lim != '0) && (nxt_small == lim);
      r.cnt = r.hit ? '0 : {{(PT_CNT_W-PT_LIM_W){1'b0}}, nxt_small};
    end
    return r;
  endfunction

  // register image of one processor window (mode offset handled above)
  function automatic logic [31:0] pt_read(input logic user,
                                          input logic [2:0] off,
                                          input logic [PT_CNT_W-1:0] cnt,
                                          input logic [PT_LIM_W-1:0] lim,
                                          input logic reached,
                                          input logic run);
    logic [31:0] v;
    v = '0;
    case (off)
      PT_OFF_HI:  v = user ? {reached, cnt[PT_CNT_W-1:PT_LO_W]}
                           : {1'b0, lim, {PT_STEP_LSB{1'b0}}};
      PT_OFF_LO:  v = user ? {cnt[PT_LO_W-1:0], {PT_STEP_LSB{1'b0}}}
                           : {reached, cnt[PT_LIM_W-1:0], {PT_STEP_LSB{1'b0}}};
      PT_OFF_RUN: v = {31'b0, run};
      default:    v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ptmr_mode_reg.sv
module ptmr_mode_reg #(
  parameter int unsigned NUM_PROC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr_i,
  input  logic [NUM_PROC-1:0] wdata_i,
  output logic [NUM_PROC-1:0] mode_q_o,
  output logic [NUM_PROC-1:0] to_user_o,
  output logic [NUM_PROC-1:0] to_cnt_o
);

  logic [NUM_PROC-1:0] mode_q;
  logic [NUM_PROC-1:0] changed;

  // only bits that differ from the stored vector produce an event
  assign changed   = mode_wr_i ? (wdata_i ^ mode_q) : '0;
  assign to_user_o = changed & wdata_i;
  assign to_cnt_o  = changed & ~wdata_i;
  assign mode_q_o  = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= '0;
    else if (mode_wr_i) mode_q <= wdata_i;
  end

  assert_mode_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> (mode_q == $past(wdata_i)));

  assert_mode_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_i |=> $stable(mode_q));

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
  import ptmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        user_i,
  input  logic        to_user_i,
  input  logic        to_cnt_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [2:0]  off_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);

  logic [PT_CNT_W-1:0] cnt_q;
  logic [PT_LIM_W-1:0] lim_q;
  logic                reached_q;
  logic                irq_q;
  logic                run_q;

  logic     wr_hi, wr_lo, wr_limk, wr_run;
  logic     mode_evt, cnt_load, advance, lim_hit, rd_ack;
  pt_step_t stp;

  assign wr_hi    = wr_i && (off_i == PT_OFF_HI);
  assign wr_lo    = wr_i && (off_i == PT_OFF_LO);
  assign wr_limk  = wr_i && (off_i == PT_OFF_LIMK);
  assign wr_run   = wr_i && (off_i == PT_OFF_RUN);
  assign mode_evt = to_user_i | to_cnt_i;

  // writes that replace the count take the cycle; no step then
  assign cnt_load = user_i ? (wr_hi | wr_lo) : wr_hi;
  assign advance  = tick_i && (!user_i || run_q) && !cnt_load && !mode_evt;
  assign stp      = pt_step(cnt_q, user_i, lim_q);
  assign lim_hit  = advance && stp.hit && !user_i;
  assign rd_ack   = rd_i && (off_i == PT_OFF_HI) && !user_i && !mode_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      run_q     <= 1'b1;
    end else if (to_user_i) begin
      cnt_q     <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else if (to_cnt_i) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (cnt_load) begin
        if (!user_i) begin
          lim_q <= wdata_i[30:PT_STEP_LSB];
          cnt_q <= '0;
          irq_q <= 1'b0;
        end else if (wr_hi) begin
          cnt_q[PT_CNT_W-1:PT_LO_W] <= wdata_i[PT_HI_W-1:0];
          reached_q <= 1'b0;
        end else begin
          cnt_q[PT_LO_W-1:0] <= wdata_i[31:PT_STEP_LSB];
          reached_q <= 1'b0;
        end
      end
      if (wr_limk) lim_q <= wdata_i[30:PT_STEP_LSB];
      if (wr_run)  run_q <= wdata_i[0];
      if (rd_ack) begin
        reached_q <= 1'b0;
        irq_q     <= 1'b0;
      end
      // a match in the same cycle as an acknowledge wins
      if (advance) begin
        cnt_q <= stp.cnt;
        if (stp.hit) begin
          reached_q <= 1'b1;
          if (!user_i) irq_q <= 1'b1;
        end
      end
    end
  end

  assign rdata_o = pt_read(user_i, off_i, cnt_q, lim_q, reached_q, run_q);
  assign irq_o   = irq_q;

  assert_user_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    user_i |-> !irq_q);

  assert_irq_from_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(lim_hit));

  assert_match_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lim_hit |=> (cnt_q == '0) && reached_q);

  assert_stopped_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (user_i && !run_q && !cnt_load && !mode_evt) |=> $stable(cnt_q));

  assert_load_clears_reached_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (user_i && cnt_load && !mode_evt) |=> !reached_q);

  assert_to_user_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    to_user_i |=> !irq_q && (cnt_q == '0));

endmodule

// File: rtl/ptmr_cluster.sv
module ptmr_cluster
  import ptmr_pkg::*;
#(
  parameter  int unsigned NUM_PROC = 2,
  localparam int unsigned SEL_W    = $clog2(NUM_PROC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [SEL_W-1:0]    bus_sel_i,
  input  logic [2:0]          bus_off_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic [NUM_PROC-1:0] irq_o
);

  logic [NUM_PROC-1:0] mode_vec;
  logic [NUM_PROC-1:0] to_user;
  logic [NUM_PROC-1:0] to_cnt;
  logic                sys_mode_wr;
  logic                mode_rd;
  logic [31:0]         core_rd [NUM_PROC];

  assign sys_mode_wr = bus_wr_i && (bus_sel_i == '0) && (bus_off_i == PT_OFF_MODE);
  assign mode_rd     = (bus_off_i == PT_OFF_MODE) && (bus_sel_i <= SEL_W'(NUM_PROC));

  ptmr_mode_reg #(.NUM_PROC(NUM_PROC)) i_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr_i (sys_mode_wr),
    .wdata_i   (bus_wdata_i[NUM_PROC-1:0]),
    .mode_q_o  (mode_vec),
    .to_user_o (to_user),
    .to_cnt_o  (to_cnt)
  );

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_proc
    logic hit;
    assign hit = (bus_sel_i == SEL_W'(g + 1));
    ptmr_core i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .user_i    (mode_vec[g]),
      .to_user_i (to_user[g]),
      .to_cnt_i  (to_cnt[g]),
      .wr_i      (bus_wr_i && hit),
      .rd_i      (bus_rd_i && hit),
      .off_i     (bus_off_i),
      .wdata_i   (bus_wdata_i),
      .rdata_o   (core_rd[g]),
      .irq_o     (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (mode_rd) begin
      bus_rdata_o = 32'(mode_vec);
    end else begin
      for (int p = 0; p < NUM_PROC; p++) begin
        if (bus_sel_i == SEL_W'(p + 1)) bus_rdata_o = core_rd[p];
      end
    end
  end

  assert_proc_mode_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && (bus_sel_i != '0) && (bus_off_i == PT_OFF_MODE)) |=> $stable(mode_vec));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0) && (mode_vec == '0));

endmodule

// File: tb/test_ptmr_cluster.sv
module test_ptmr_cluster;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_sel = '0;
  logic [2:0]  bus_off = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ptmr_cluster #(.NUM_PROC(NP)) i_ptmr_cluster (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_sel_i(bus_sel),
    .bus_off_i(bus_off), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  // ---------------- reference model: visible values in byte units ----------
  logic [63:0] m_val [NP];
  logic [63:0] m_lim [NP];
  bit m_reach [NP];
  bit m_irq   [NP];
  bit m_run   [NP];
  bit m_user  [NP];

  always @(posedge clk) begin : model
    logic [63:0] olim, nv;
    bit orun, blk;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_val[p] = 0; m_lim[p] = 0; m_reach[p] = 0;
        m_irq[p] = 0; m_run[p] = 1; m_user[p] = 0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (bus_wr && bus_sel == 0 && bus_off == 4 && bus_wdata[p] != m_user[p]) begin
          m_val[p] = 0; m_reach[p] = 0; m_irq[p] = 0;
          if (!bus_wdata[p]) m_lim[p] = 0;
          m_user[p] = bus_wdata[p];
        end else begin
          olim = m_lim[p]; orun = m_run[p]; blk = 0;
          if (bus_wr && bus_sel == 2'(p + 1)) begin
            case (bus_off)
              3'd0: begin
                blk = 1;
                if (m_user[p]) begin
                  m_val[p] = ({32'b0, bus_wdata & 32'h7FFF_FFFF} << 32) | (m_val[p] & 64'hFFFF_FFFF);
                  m_reach[p] = 0;
                end else begin
                  m_lim[p] = {32'b0, bus_wdata & 32'h7FFF_FE00};
                  m_val[p] = 0; m_irq[p] = 0;
                end
              end
              3'd1: if (m_user[p]) begin
                blk = 1;
                m_val[p] = (m_val[p] & 64'hFFFF_FFFF_0000_0000) | {32'b0, bus_wdata & 32'hFFFF_FE00};
                m_reach[p] = 0;
              end
              3'd2: m_lim[p] = {32'b0, bus_wdata & 32'h7FFF_FE00};
              3'd3: m_run[p] = bus_wdata[0];
              default: ;
            endcase
          end
          if (bus_rd && bus_sel == 2'(p + 1) && bus_off == 0 && !m_user[p]) begin
            m_reach[p] = 0; m_irq[p] = 0;
          end
          if (!blk && tick && (!m_user[p] || orun)) begin
            nv = m_val[p] + 64'd512;
            if (m_user[p]) begin
              if (nv == 64'h7FFF_FFFF_FFFF_FE00) begin m_val[p] = 0; m_reach[p] = 1; end
              else m_val[p] = nv;
            end else if (olim != 0 && nv == olim) begin
              m_val[p] = 0; m_reach[p] = 1; m_irq[p] = 1;
            end else if (nv == 64'h8000_0000) m_val[p] = 0;
            else m_val[p] = nv;
          end
        end
      end
    end
  end

  function automatic logic [31:0] model_read(int s, int o);
    logic [31:0] mv;
    mv = '0;
    for (int p = 0; p < NP; p++) mv[p] = m_user[p];
    if (o == 4) return (s <= NP) ? mv : 32'h0;
    if (s == 0 || s > NP) return 32'h0;
    case (o)
      0: return m_user[s-1] ? {m_reach[s-1], m_val[s-1][62:32]} : m_lim[s-1][31:0];
      1: return m_user[s-1] ? m_val[s-1][31:0] : {m_reach[s-1], m_val[s-1][30:0]};
      3: return {31'b0, m_run[s-1]};
      default: return 32'h0;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // interrupt compared with the model on every cycle
  always @(negedge clk) begin
    if (rst_n) check({cur_tag, " irq"}, 32'(irq), {30'b0, m_irq[1], m_irq[0]});
  end

  task automatic drive(bit w, bit r, int s, int o, logic [31:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_sel = 2'(s); bus_off = 3'(o); bus_wdata = d;
  endtask

  task automatic rd_chk(int s, int o, string tag);
    drive(0, 1, s, o, 32'h0);
    #1 check(tag, bus_rdata, model_read(s, o));
  endtask

  task automatic wr(int s, int o, logic [31:0] d);
    drive(1, 0, s, o, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 32'h0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog all-requirements act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset image of every register
    cur_tag = "R1";
    for (int s = 1; s <= NP; s++) begin
      check("R1 limit", model_read(s, 0), 32'h0);
      for (int o = 0; o < 5; o++) rd_chk(s, o, "R1");
    end
    rd_chk(0, 4, "R1");
    check("R1 run bit", model_read(1, 3), 32'h1);

    // R2: limit of 5 steps, match and interrupt
    cur_tag = "R2";
    wr(1, 0, 32'h0000_0A00);
    tick = 1'b1;
    for (int i = 0; i < 12; i++) rd_chk(1, 1, "R2");
    check("R2 irq pending", 32'(irq[0]), 32'h1);

    // R3: acknowledge, reload, ignored lower-word write
    cur_tag = "R3";
    rd_chk(1, 0, "R3");
    rd_chk(1, 1, "R3");
    wr(1, 0, 32'h0000_1400);
    rd_chk(1, 1, "R3");
    wr(1, 1, 32'hFFFF_FE00);
    rd_chk(1, 1, "R3");

    // R4: limit change without restart
    cur_tag = "R4";
    idle(3);
    wr(1, 2, 32'h0000_3000);
    for (int i = 0; i < 8; i++) rd_chk(1, 1, "R4");
    rd_chk(1, 0, "R4");

    // R5: free-running counter mode
    cur_tag = "R5";
    wr(1, 0, 32'h0);
    idle(40);
    rd_chk(1, 1, "R5");
    check("R5 no irq", 32'(irq[0]), 32'h0);

    // R6: mode vector only writable through the system window
    cur_tag = "R6";
    wr(1, 4, 32'h1);
    rd_chk(0, 4, "R6");
    rd_chk(2, 4, "R6");
    wr(0, 4, 32'h1);
    rd_chk(0, 4, "R6");
    rd_chk(1, 4, "R6");

    // R10: entry into user mode
    cur_tag = "R10";
    rd_chk(1, 3, "R10");
    rd_chk(1, 1, "R10");

    // R7: split-word load and read
    cur_tag = "R7";
    wr(1, 0, 32'h0000_0012);
    rd_chk(1, 0, "R7");
    wr(1, 1, 32'h8000_0000);
    rd_chk(1, 1, "R7");
    rd_chk(1, 0, "R7");

    // R8: stop/start in user mode, stored-only in counter mode
    cur_tag = "R8";
    wr(1, 3, 32'h0);
    idle(5);
    rd_chk(1, 1, "R8");
    rd_chk(1, 1, "R8");
    rd_chk(1, 3, "R8");
    wr(1, 3, 32'h1);
    idle(3);
    rd_chk(1, 1, "R8");
    wr(2, 3, 32'h0);
    rd_chk(2, 3, "R8");
    rd_chk(2, 1, "R8");
    idle(2);
    rd_chk(2, 1, "R8");

    // R9: user-mode wrap at the top of the count
    cur_tag = "R9";
    tick = 1'b0;
    wr(1, 0, 32'h7FFF_FFFF);
    wr(1, 1, 32'hFFFF_FA00);
    rd_chk(1, 0, "R9");
    tick = 1'b1;
    for (int i = 0; i < 4; i++) rd_chk(1, 1, "R9");
    rd_chk(1, 0, "R9");
    rd_chk(1, 0, "R9");
    check("R9 user irq low", 32'(irq[0]), 32'h0);

    // R10: second timer enters user mode with its interrupt pending,
    //      first timer's bit rewritten unchanged
    cur_tag = "R10";
    wr(2, 0, 32'h0000_0800);
    idle(6);
    check("R10 irq before switch", 32'(irq[1]), 32'h1);
    rd_chk(1, 1, "R10");
    wr(0, 4, 32'h3);
    rd_chk(1, 1, "R10");
    rd_chk(2, 1, "R10");
    idle(3);
    rd_chk(2, 1, "R10");
    rd_chk(2, 3, "R10");
    check("R10 irq lowered", 32'(irq[1]), 32'h0);

    // R11: both timers back to counter mode
    cur_tag = "R11";
    wr(0, 4, 32'h0);
    rd_chk(1, 0, "R11");
    rd_chk(1, 1, "R11");
    idle(4);
    rd_chk(1, 1, "R11");
    rd_chk(2, 1, "R11");
    rd_chk(0, 4, "R11");

    idle(2);
    finish_run();
  end
endmodule